// File: doc/BRIEF.md
# Supervisor User-Page Access Checker

This block sits in the permission stage of a paged load/store unit. For every data access or instruction fetch it works out the privilege that the access actually runs at. A machine-mode load or store can be redirected by a modify-privilege enable to the privilege held in a saved-privilege field. It then decides whether the page's user-accessible tag allows the access. A single control bit, `userOpen`, lets accesses at effective supervisor privilege reach user-tagged pages. This lets kernel code work on application buffers without changing mode.

The grant is a combinational function of the current inputs. A page fault, with a cause code picked by the access type, is registered and appears one clock after the access strobe. When paging is off, the user-tag check is skipped. A build parameter removes supervisor-mode support, and the open bit then has no effect. Page table walks, the TLB and the read/write/execute permission bits are handled elsewhere.

Top module: `userPageGuard`

## Requirements
- R1: During and straight after reset, `faultValid` is 0 and `faultCause` is 0.
- R2: With paging on, `userOpen`=0 and an access at effective supervisor privilege (encoding 01) to a page with `pageUserBit`=1, `grant` is 0 and a fault follows.
- R3: With paging on, `userOpen`=1 and supervisor support built in, an effective-supervisor access to a user-tagged page is granted.
- R4: With `pagingOn`=0, every valid access is granted whatever `userOpen`, `pageUserBit` or privilege hold.
- R5: When `curPriv` is machine (11), `modPrivEn`=1 and the access is a load or store, the effective privilege is `prevPriv`. With `prevPriv`=01, `userOpen` then decides user-page accesses.
- R6: An instruction fetch (`accType`=10) always uses `curPriv`, ignoring `modPrivEn` and `prevPriv`.
- R7: An access at effective user privilege (00) to a page with `pageUserBit`=0 is denied whatever `userOpen` holds.
- R8: An access at effective machine privilege is always granted.
- R9: The reserved privilege encoding 10, whether current or saved, is treated as user.
- R10: With `HAS_SMODE`=0, `userOpen` has no effect: effective-supervisor accesses to user-tagged pages are denied.
- R11: One clock after a valid denied access, `faultValid` is 1 and `faultCause` is 13 for a load (`accType` 00), 15 for a store (01 or 11), and 12 for a fetch (10). After a granted or idle cycle, `faultValid` and `faultCause` are 0.
- R12: With `accValid`=0, `grant` is 0 and no fault is raised in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curPriv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine, 10 reserved |
| modPrivEn | input | 1 | Redirects machine-mode loads/stores to `prevPriv` |
| prevPriv | input | 2 | Saved privilege used when redirection is active |
| userOpen | input | 1 | Lets supervisor accesses reach user-tagged pages |
| pagingOn | input | 1 | Page-based translation is active |
| pageUserBit | input | 1 | Page is tagged user-accessible |
| accValid | input | 1 | An access is presented this cycle |
| accType | input | 2 | 00 load, 01 store, 10 fetch, 11 store |
| grant | output | 1 | Access allowed (combinational) |
| faultValid | output | 1 | Page fault for the previous cycle's access (registered) |
| faultCause | output | 5 | Page fault cause code (registered) |

## Verification
`grant` depends only on the inputs of the same cycle. The bench therefore drives each access after a falling edge and samples `grant` one nanosecond later, before the next rising edge. `faultValid` and `faultCause` belong to the access presented in the cycle before. The bench samples them one nanosecond after the following rising edge and compares them with the model's verdict for the inputs it held during that cycle. A second instance built without supervisor support gets the same stimulus, so the open bit can be seen to have no effect there.

// File: rtl/upgPkg.sv
package upgPkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } privLevel_t;

  typedef enum logic [1:0] {
    ACC_LOAD   = 2'b00,
    ACC_STORE  = 2'b01,
    ACC_FETCH  = 2'b10,
    ACC_STORE2 = 2'b11
  } accKind_t;

  // Strobes sent from the control decoder to the datapath
  typedef struct packed {
    logic checkOn;   // valid access with paging active
    logic useSaved;  // effective privilege comes from the saved field
    logic isFetch;
    logic isStore;
    logic openEff;   // open bit after the build option is applied
  } upgStrobes_t;

endpackage

// File: rtl/upgCtrl.sv
module upgCtrl
  import upgPkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic [1:0]  curPriv,
  input  logic        modPrivEn,
  input  logic        userOpen,
  input  logic        pagingOn,
  input  logic        accValid,
  input  logic [1:0]  accType,
  output upgStrobes_t strobes
);

  logic fetchAcc;
  logic machNow;

  assign fetchAcc = (accType == ACC_FETCH);
  assign machNow  = (curPriv == PRIV_MACH);

  always_comb begin
    strobes.checkOn  = accValid & pagingOn;
    strobes.isFetch  = fetchAcc;
    strobes.isStore  = accType[0];
    strobes.useSaved = machNow & modPrivEn & ~fetchAcc;
  end

  generate
    if (HAS_SMODE) begin : gOpenLive
      always_comb strobes.openEff = userOpen;
    end else begin : gOpenTied
      logic unusedOpen;
      assign unusedOpen = userOpen;
      always_comb strobes.openEff = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/upgData.sv
module upgData
  import upgPkg::*;
#(
  parameter int CAUSE_W     = 5,
  parameter int CAUSE_LOAD  = 13,
  parameter int CAUSE_STORE = 15,
  parameter int CAUSE_FETCH = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  upgStrobes_t        strobes,
  input  logic               accValid,
  input  logic [1:0]         curPriv,
  input  logic [1:0]         prevPriv,
  input  logic               pageUserBit,
  output logic               grant,
  output logic               faultValid,
  output logic [CAUSE_W-1:0] faultCause
);

  localparam logic [CAUSE_W-1:0] C_LOAD  = CAUSE_W'(CAUSE_LOAD);
  localparam logic [CAUSE_W-1:0] C_STORE = CAUSE_W'(CAUSE_STORE);
  localparam logic [CAUSE_W-1:0] C_FETCH = CAUSE_W'(CAUSE_FETCH);

  logic [1:0]         rawPriv;
  privLevel_t         effPriv;
  logic               deny;
  logic [CAUSE_W-1:0] causeNext;

  assign rawPriv = strobes.useSaved ? prevPriv : curPriv;

  always_comb begin
    case (rawPriv)
      2'b01:   effPriv = PRIV_SUPER;
      2'b11:   effPriv = PRIV_MACH;
      default: effPriv = PRIV_USER;  // 00 and reserved 10
    endcase
  end

  always_comb begin
    deny = 1'b0;
    if (strobes.checkOn) begin
      unique case (effPriv)
        PRIV_SUPER: deny = pageUserBit & ~strobes.openEff;
        PRIV_USER:  deny = ~pageUserBit;
        default:    deny = 1'b0;
      endcase
    end
  end

  assign grant = accValid & ~deny;

  always_comb begin
    if (strobes.isFetch)      causeNext = C_FETCH;
    else if (strobes.isStore) causeNext = C_STORE;
    else                      causeNext = C_LOAD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultValid <= 1'b0;
      faultCause <= '0;
    end else begin
      faultValid <= deny;
      faultCause <= deny ? causeNext : '0;
    end
  end

endmodule

// File: rtl/userPageGuard.sv
module userPageGuard
  import upgPkg::*;
#(
  parameter bit HAS_SMODE   = 1'b1,
  parameter int CAUSE_W     = 5,
  parameter int CAUSE_LOAD  = 13,
  parameter int CAUSE_STORE = 15,
  parameter int CAUSE_FETCH = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         curPriv,
  input  logic               modPrivEn,
  input  logic [1:0]         prevPriv,
  input  logic               userOpen,
  input  logic               pagingOn,
  input  logic               pageUserBit,
  input  logic               accValid,
  input  logic [1:0]         accType,
  output logic               grant,
  output logic               faultValid,
  output logic [CAUSE_W-1:0] faultCause
);

  upgStrobes_t strobes;

  upgCtrl #(.HAS_SMODE(HAS_SMODE)) uCtrl (
    .curPriv  (curPriv),
    .modPrivEn(modPrivEn),
    .userOpen (userOpen),
    .pagingOn (pagingOn),
    .accValid (accValid),
    .accType  (accType),
    .strobes  (strobes)
  );

  upgData #(
    .CAUSE_W    (CAUSE_W),
    .CAUSE_LOAD (CAUSE_LOAD),
    .CAUSE_STORE(CAUSE_STORE),
    .CAUSE_FETCH(CAUSE_FETCH)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .accValid   (accValid),
    .curPriv    (curPriv),
    .prevPriv   (prevPriv),
    .pageUserBit(pageUserBit),
    .grant      (grant),
    .faultValid (faultValid),
    .faultCause (faultCause)
  );

endmodule

// File: rtl/userPageGuardSva.sv
module userPageGuardSva #(
  parameter bit HAS_SMODE   = 1'b1,
  parameter int CAUSE_W     = 5,
  parameter int CAUSE_LOAD  = 13,
  parameter int CAUSE_STORE = 15,
  parameter int CAUSE_FETCH = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         curPriv,
  input logic               modPrivEn,
  input logic [1:0]         prevPriv,
  input logic               userOpen,
  input logic               pagingOn,
  input logic               pageUserBit,
  input logic               accValid,
  input logic [1:0]         accType,
  input logic               grant,
  input logic               faultValid,
  input logic [CAUSE_W-1:0] faultCause
);

  logic dataAcc;
  logic superEff;
  assign dataAcc  = (accType != 2'b10);
  assign superEff = (curPriv == 2'b01) |
                    ((curPriv == 2'b11) & modPrivEn & dataAcc & (prevPriv == 2'b01));

  // R12
  a_r12_idle_no_grant: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !grant);

  // R4
  a_r4_paging_off_grants: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !pagingOn) |-> grant);

  // R8
  a_r8_machine_grants: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && curPriv == 2'b11 && (!modPrivEn || !dataAcc)) |-> grant);

  // R7 and R9
  a_r7_user_needs_tag: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && pagingOn && !curPriv[0] && !pageUserBit) |-> !grant);

  // R2
  a_r2_closed_denies: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && pagingOn && superEff && pageUserBit && !userOpen) |-> !grant);

  // R11
  a_r11_fault_follows_deny: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (faultValid == $past(accValid && !grant)));

  a_r11_cause_legal: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (faultCause == CAUSE_W'(CAUSE_LOAD) ||
                    faultCause == CAUSE_W'(CAUSE_STORE) ||
                    faultCause == CAUSE_W'(CAUSE_FETCH)));

  a_r11_quiet_cause: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |-> (faultCause == '0));

  generate
    if (HAS_SMODE) begin : gOpen
      // R3
      a_r3_open_grants: assert property (@(posedge clk) disable iff (!rstN)
        (accValid && pagingOn && superEff && pageUserBit && userOpen) |-> grant);
    end else begin : gNoS
      // R10
      a_r10_open_ignored: assert property (@(posedge clk) disable iff (!rstN)
        (accValid && pagingOn && superEff && pageUserBit) |-> !grant);
    end
  endgenerate

endmodule

bind userPageGuard userPageGuardSva #(
  .HAS_SMODE  (HAS_SMODE),
  .CAUSE_W    (CAUSE_W),
  .CAUSE_LOAD (CAUSE_LOAD),
  .CAUSE_STORE(CAUSE_STORE),
  .CAUSE_FETCH(CAUSE_FETCH)
) uSva (.*);

// File: tb/sim_userPageGuard.sv
module sim_userPageGuard;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] curPriv;
  logic       modPrivEn;
  logic [1:0] prevPriv;
  logic       userOpen;
  logic       pagingOn;
  logic       pageUserBit;
  logic       accValid;
  logic [1:0] accType;

  logic       grant0, grant1;
  logic       fv0, fv1;
  logic [4:0] fc0, fc1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  userPageGuard #(.HAS_SMODE(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .curPriv(curPriv), .modPrivEn(modPrivEn),
    .prevPriv(prevPriv), .userOpen(userOpen), .pagingOn(pagingOn),
    .pageUserBit(pageUserBit), .accValid(accValid), .accType(accType),
    .grant(grant0), .faultValid(fv0), .faultCause(fc0));

  userPageGuard #(.HAS_SMODE(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .curPriv(curPriv), .modPrivEn(modPrivEn),
    .prevPriv(prevPriv), .userOpen(userOpen), .pagingOn(pagingOn),
    .pageUserBit(pageUserBit), .accValid(accValid), .accType(accType),
    .grant(grant1), .faultValid(fv1), .faultCause(fc1));

  // Reference model
  function automatic int modelPriv();
    int p;
    if (accType != 2'b10 && curPriv == 2'b11 && modPrivEn) p = prevPriv;
    else p = curPriv;
    if (p == 2) p = 0;
    return p;
  endfunction

  function automatic bit modelDeny(bit hasS);
    int p;
    if (!accValid || !pagingOn) return 1'b0;
    p = modelPriv();
    if (p == 3) return 1'b0;
    if (p == 1) return pageUserBit && !(userOpen && hasS);
    return !pageUserBit;
  endfunction

  function automatic int modelCause();
    if (accType == 2'b10) return 12;
    if (accType[0]) return 15;
    return 13;
  endfunction

  function automatic string tagFor(bit hasS);
    int p;
    if (!accValid) return "R12";
    if (!pagingOn) return "R4";
    if (curPriv == 2'b11 && modPrivEn && accType == 2'b10) return "R6";
    if (curPriv == 2'b11 && modPrivEn) return "R5";
    p = modelPriv();
    if (p == 3) return "R8";
    if (curPriv == 2'b10) return "R9";
    if (p == 0) return "R7";
    if (!hasS) return "R10";
    return userOpen ? "R3" : "R2";
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [1:0] cp, logic mp, logic [1:0] pp, logic uo,
                      logic pg, logic ub, logic av, logic [1:0] at);
    bit d0, d1;
    int cz;
    @(negedge clk);
    curPriv = cp; modPrivEn = mp; prevPriv = pp; userOpen = uo;
    pagingOn = pg; pageUserBit = ub; accValid = av; accType = at;
    #1;
    d0 = modelDeny(1'b1);
    d1 = modelDeny(1'b0);
    cz = modelCause();
    check(tagFor(1'b1), int'(grant0), int'(av && !d0), "grant u0");
    check(tagFor(1'b0), int'(grant1), int'(av && !d1), "grant u1");
    @(posedge clk);
    #1;
    check("R11", int'(fv0), int'(d0), "faultValid u0");
    check("R11", int'(fc0), d0 ? cz : 0, "faultCause u0");
    check("R11", int'(fv1), int'(d1), "faultValid u1");
    check("R11", int'(fc1), d1 ? cz : 0, "faultCause u1");
  endtask

  initial begin
    rstN = 1'b0;
    curPriv = 2'b11; modPrivEn = 1'b0; prevPriv = 2'b00; userOpen = 1'b0;
    pagingOn = 1'b1; pageUserBit = 1'b0; accValid = 1'b1; accType = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(fv0), 0, "faultValid in reset");
    check("R1", int'(fc0), 0, "faultCause in reset");
    @(negedge clk);
    rstN = 1'b1;
    accValid = 1'b0;
    @(posedge clk);
    #1;
    check("R1", int'(fv0), 0, "faultValid after reset");
    check("R1", int'(fc1), 0, "faultCause after reset");

    // args: cur, mprv, mpp, open, paging, userBit, valid, type
    step(2'b01, 0, 2'b00, 0, 1, 1, 1, 2'b00); // R2 load deny
    step(2'b01, 0, 2'b00, 0, 1, 1, 1, 2'b01); // R2 store deny
    step(2'b01, 0, 2'b00, 1, 1, 1, 1, 2'b00); // R3 open grants / R10 denies
    step(2'b01, 0, 2'b00, 0, 0, 1, 1, 2'b01); // R4 paging off
    step(2'b00, 0, 2'b00, 0, 0, 0, 1, 2'b00); // R4 user, paging off
    step(2'b11, 1, 2'b01, 0, 1, 1, 1, 2'b00); // R5 redirected to S, closed
    step(2'b11, 1, 2'b01, 1, 1, 1, 1, 2'b01); // R5 redirected to S, open
    step(2'b11, 1, 2'b00, 1, 1, 0, 1, 2'b11); // R5 redirected to U, store2
    step(2'b11, 1, 2'b00, 0, 1, 0, 1, 2'b10); // R6 fetch ignores redirect
    step(2'b01, 1, 2'b11, 0, 1, 1, 1, 2'b10); // R2 fetch in S
    step(2'b00, 0, 2'b00, 1, 1, 0, 1, 2'b00); // R7 user non-user page
    step(2'b00, 0, 2'b00, 1, 1, 1, 1, 2'b01); // user page ok
    step(2'b11, 0, 2'b01, 0, 1, 1, 1, 2'b00); // R8 machine
    step(2'b10, 0, 2'b00, 0, 1, 0, 1, 2'b00); // R9 reserved current
    step(2'b11, 1, 2'b10, 0, 1, 0, 1, 2'b01); // R9 reserved saved
    step(2'b00, 0, 2'b00, 0, 1, 0, 0, 2'b00); // R12 idle

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      step(r[1:0], r[2], r[4:3], r[5], r[6] | r[7], r[8], r[9] | r[10], r[12:11]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule